// File: doc/BRIEF.md
# Timer control and interrupt flag register

This block is an 8-bit control and status register that serves two timers and two external interrupt inputs. Software reaches it through a simple read/write port. Each write carries a per-bit mask, so a single bit can be changed without a read-modify-write. The register holds a run enable for each timer and drives it straight out to that timer. It also keeps a sticky overflow flag per timer, which a one-cycle overflow pulse sets.

The two external interrupt pins are asynchronous. Each passes through a two-flop synchronizer and then through a polarity qualifier. A mode bit per input chooses how the flag behaves. In level mode the interrupt flag copies the qualified active level every cycle. In edge mode the flag is sticky: it is set when the qualified signal moves from inactive to active.

Vector-acknowledge inputs stand for the CPU entering an interrupt service routine. They clear the timer flags, and they clear the external flags only in edge mode. When a hardware set meets a software clear in the same cycle, the set wins.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset every register bit is 0, and `tmr_run`, `tmr_irq` and `ext_irq` are all 0.
- R2: The register answers only at address 0x88. Reads there return bit 7 timer-1 flag, bit 6 timer-1 run, bit 5 timer-0 flag, bit 4 timer-0 run, bit 3 ext-1 flag, bit 2 ext-1 mode, bit 1 ext-0 flag, bit 0 ext-0 mode. Reads at any other address return 0, and writes there change nothing.
- R3: A write at 0x88 updates only the bits whose `reg_wmask` bit is 1. The new value appears one cycle after the write.
- R4: `tmr_run[i]` equals the timer-i run bit (bit 4 for timer 0, bit 6 for timer 1).
- R5: A `tmr_ovf[i]` pulse sets the timer-i flag in the next cycle. This holds even if an acknowledge or a software write of 0 hits that flag in the same cycle.
- R6: A timer flag is cleared by `tmr_vec_ack[i]` or by a masked software write of 0.
- R7: The mode bit of an external input selects its detection: 0 is level mode, 1 is edge mode.
- R8: In edge mode, a change of the pin from inactive to active sets the flag 3 cycles later (two synchronizer stages plus detection). The flag stays set until `ext_vec_ack[i]` or a software write of 0 clears it. A held active level does not set it again.
- R9: In level mode, the flag equals the qualified pin level delayed by 3 cycles. Acknowledges and software writes have no effect on it.
- R10: `ext_pol[i]`=1 makes a high pin active, and 0 makes a low pin active.
- R11: In the first 3 cycles after reset, no edge event is produced while the synchronizer history is still filling. A pin held active through reset therefore does not set an edge-mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wmask | input | 8 | Per-bit write enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (0 when the address does not match) |
| tmr_ovf | input | 2 | One-cycle overflow pulse per timer |
| tmr_vec_ack | input | 2 | CPU vectored to a timer's service routine |
| tmr_run | output | 2 | Run enable per timer |
| tmr_irq | output | 2 | Timer overflow flags |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| ext_pol | input | 2 | Active polarity per pin (1 = high) |
| ext_vec_ack | input | 2 | CPU vectored to an external service routine |
| ext_irq | output | 2 | External interrupt flags |

## Verification
The bench drives three collisions on one flag in a single cycle: an overflow, an acknowledge and a software clear. If the priority were wrong, an overflow would be lost.

It also checks that an acknowledge and a write in level mode leave the flag following the pin. A design that cleared the flag there would drop a request that is still asserted.

The bench counts the exact three-cycle latency of the synchronizer. It holds a pin active through reset, where a missing warm-up guard would raise a false edge. It flips the polarity and expects the qualified level to invert.

Seeded random traffic with masked writes to the matching and to foreign addresses catches writes that leak across bits or across addresses.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int REG_W = 8;
  localparam int N_CH  = 2;

  // Field positions inside the control byte (software depends on these)
  function automatic int mode_pos(int ch); return 2 * ch;     endfunction
  function automatic int eflg_pos(int ch); return 2 * ch + 1; endfunction
  function automatic int run_pos (int ch); return 4 + 2 * ch; endfunction
  function automatic int tflg_pos(int ch); return 5 + 2 * ch; endfunction

  // A pin is active when its synchronized value matches the polarity bit
  function automatic logic qual_level(logic raw, logic pol);
    return raw ~^ pol;
  endfunction

  function automatic logic rise_of(logic cur, logic prev);
    return cur & ~prev;
  endfunction

  // Sticky flag: hardware set beats acknowledge, which beats a software write
  function automatic logic sticky_next(logic cur, logic hw_set, logic ack,
                                       logic we, logic wd);
    if (hw_set)  return 1'b1;
    if (ack)     return 1'b0;
    if (we)      return wd;
    return cur;
  endfunction
endpackage

// File: rtl/tic_pin_qual.sv
module tic_pin_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic act,
  output logic hit
);
  import tic_pkg::*;

  localparam int WARM_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WARM_W-1:0]      warm_q;
  logic                   prev_q;
  logic                   s_valid;
  logic                   p_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      warm_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      warm_q <= {warm_q[WARM_W-2:0], 1'b1};
      prev_q <= act;
    end
  end

  assign s_valid = warm_q[SYNC_STAGES-1];
  assign p_valid = warm_q[SYNC_STAGES];
  assign act     = s_valid & qual_level(sync_q[SYNC_STAGES-1], pol);
  assign hit     = p_valid & rise_of(act, prev_q);

  // R8: an edge event only when the qualified level was inactive last cycle
  a_r8_hit_is_rise: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (act && !$past(act)));
endmodule

// File: rtl/tic_ext_slot.sv
module tic_ext_slot #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_we,
  input  logic mode_wd,
  input  logic flag_we,
  input  logic flag_wd,
  input  logic pin,
  input  logic pol,
  input  logic ack,
  output logic mode,
  output logic flag
);
  import tic_pkg::*;

  logic act;
  logic hit;
  logic mode_q;
  logic flag_q;

  tic_pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .pol  (pol),
    .act  (act),
    .hit  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wd;
      if (mode_q) flag_q <= sticky_next(flag_q, hit, ack, flag_we, flag_wd);
      else        flag_q <= act;
    end
  end

  assign mode = mode_q;
  assign flag = flag_q;

  // R9: level mode copies the qualified level, whatever ack or write do
  a_r9_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> (flag_q == $past(act)));
  // R8: edge event sets the flag
  a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && hit) |=> flag_q);
  // R8: acknowledge clears an edge-mode flag when no new edge arrives
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && ack && !hit) |=> !flag_q);
endmodule

// File: rtl/tic_tmr_slot.sv
module tic_tmr_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic run_we,
  input  logic run_wd,
  input  logic flag_we,
  input  logic flag_wd,
  input  logic ovf,
  input  logic ack,
  output logic run,
  output logic flag
);
  import tic_pkg::*;

  logic run_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (run_we) run_q <= run_wd;
      flag_q <= sticky_next(flag_q, ovf, ack, flag_we, flag_wd);
    end
  end

  assign run  = run_q;
  assign flag = flag_q;

  // R5: overflow always lands in the flag
  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);
  // R6: acknowledge clears the flag when no overflow coincides
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ovf) |=> !flag);
  // R3: the run bit moves only when written
  a_r3_run_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !run_we |=> $stable(run));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter logic [7:0] ADDR        = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wmask,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] tmr_ovf,
  input  logic [1:0] tmr_vec_ack,
  output logic [1:0] tmr_run,
  output logic [1:0] tmr_irq,
  input  logic [1:0] ext_pin,
  input  logic [1:0] ext_pol,
  input  logic [1:0] ext_vec_ack,
  output logic [1:0] ext_irq
);
  import tic_pkg::*;

  logic             addr_hit;
  logic             wr_hit;
  logic [REG_W-1:0] bit_we;
  logic [REG_W-1:0] ctl_bits;

  assign addr_hit = (reg_addr == ADDR);
  assign wr_hit   = reg_wr & addr_hit;
  assign bit_we   = {REG_W{wr_hit}} & reg_wmask;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int MP = mode_pos(ch);
    localparam int EP = eflg_pos(ch);
    localparam int RP = run_pos(ch);
    localparam int TP = tflg_pos(ch);

    tic_ext_slot #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_we(bit_we[MP]),
      .mode_wd(reg_wdata[MP]),
      .flag_we(bit_we[EP]),
      .flag_wd(reg_wdata[EP]),
      .pin    (ext_pin[ch]),
      .pol    (ext_pol[ch]),
      .ack    (ext_vec_ack[ch]),
      .mode   (ctl_bits[MP]),
      .flag   (ctl_bits[EP])
    );

    tic_tmr_slot u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_we (bit_we[RP]),
      .run_wd (reg_wdata[RP]),
      .flag_we(bit_we[TP]),
      .flag_wd(reg_wdata[TP]),
      .ovf    (tmr_ovf[ch]),
      .ack    (tmr_vec_ack[ch]),
      .run    (ctl_bits[RP]),
      .flag   (ctl_bits[TP])
    );

    assign tmr_run[ch] = ctl_bits[RP];
    assign tmr_irq[ch] = ctl_bits[TP];
    assign ext_irq[ch] = ctl_bits[EP];
  end

  assign reg_rdata = addr_hit ? ctl_bits : '0;

  // R2: writes aimed elsewhere leave the run enables untouched
  a_r2_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !addr_hit) |=> $stable(tmr_run));
endmodule

// File: tb/tmr_irq_ctl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctl_bench;
  localparam logic [7:0] ADDR = 8'h88;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = ADDR;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wmask = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] tmr_ovf = '0, tmr_vec_ack = '0, tmr_run, tmr_irq;
  logic [1:0] ext_pin = '0, ext_pol = 2'b11, ext_vec_ack = '0, ext_irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_irq_ctl u_tmr_irq_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wmask(reg_wmask), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_ovf(tmr_ovf), .tmr_vec_ack(tmr_vec_ack), .tmr_run(tmr_run),
    .tmr_irq(tmr_irq), .ext_pin(ext_pin), .ext_pol(ext_pol),
    .ext_vec_ack(ext_vec_ack), .ext_irq(ext_irq)
  );

  // ---------------- reference model built from the requirements ----------
  logic [7:0] m_reg;
  logic [1:0] h1, h2, m_prev;
  int         m_age;

  function automatic logic active(logic raw, logic pol);
    return pol ? raw : !raw;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= '0; h1 <= '0; h2 <= '0; m_prev <= '0; m_age <= 0;
    end else begin
      logic [7:0] nx;
      nx = m_reg;
      for (int c = 0; c < 2; c++) begin
        logic a, e;
        logic [7:0] w;
        w = (reg_wr && reg_addr == ADDR) ? reg_wmask : 8'h00;
        a = (m_age >= 2) && active(h2[c], ext_pol[c]);
        e = (m_age >= 3) && a && !m_prev[c];
        m_prev[c] <= a;
        if (w[2*c]) nx[2*c] = reg_wdata[2*c];
        if (m_reg[2*c]) begin
          if (e) nx[2*c+1] = 1'b1;
          else if (ext_vec_ack[c]) nx[2*c+1] = 1'b0;
          else if (w[2*c+1]) nx[2*c+1] = reg_wdata[2*c+1];
        end else nx[2*c+1] = a;
        if (w[4+2*c]) nx[4+2*c] = reg_wdata[4+2*c];
        if (tmr_ovf[c]) nx[5+2*c] = 1'b1;
        else if (tmr_vec_ack[c]) nx[5+2*c] = 1'b0;
        else if (w[5+2*c]) nx[5+2*c] = reg_wdata[5+2*c];
      end
      m_reg <= nx;
      h2 <= h1;
      h1 <= ext_pin;
      m_age <= (m_age < 3) ? m_age + 1 : 3;
    end
  end

  // ---------------- checking ---------------------------------------------
  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 read data", reg_rdata, (reg_addr == ADDR) ? m_reg : 8'h00);
    chk("R4 run enables", {6'b0, tmr_run}, {6'b0, m_reg[6], m_reg[4]});
    chk("R5 timer flags", {6'b0, tmr_irq}, {6'b0, m_reg[7], m_reg[5]});
    chk("R8 R9 ext flags", {6'b0, ext_irq}, {6'b0, m_reg[3], m_reg[1]});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] m, input logic [7:0] d);
    reg_addr = a; reg_wmask = m; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_addr = ADDR;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset register", reg_rdata, 8'h00);
    chk("R1 reset outputs", {2'b0, tmr_run, tmr_irq, ext_irq}, 8'h00);
    step();
    // R3 masked write of the run bits, R4 run outputs
    wr(ADDR, 8'h50, 8'hFF);
    chk("R3 masked set", reg_rdata, 8'h50);
    chk("R4 both timers run", {6'b0, tmr_run}, 8'h03);
    wr(ADDR, 8'h10, 8'h00);
    chk("R3 single-bit clear", reg_rdata, 8'h40);
    chk("R4 timer1 only", {6'b0, tmr_run}, 8'h02);
    // R2 foreign address
    reg_addr = 8'h89;
    reg_wr = 1'b1; reg_wmask = 8'hFF; reg_wdata = 8'hFF;
    @(negedge clk);
    chk("R2 foreign read is zero", reg_rdata, 8'h00);
    reg_wr = 1'b0; reg_addr = ADDR;
    #1 chk("R2 foreign write ignored", reg_rdata, 8'h40);
    step();
    // R5 overflow sets, and beats ack plus software clear
    tmr_ovf = 2'b01; step(); tmr_ovf = 2'b00;
    chk("R5 timer0 flag set", {6'b0, tmr_irq}, 8'h01);
    tmr_ovf = 2'b10; tmr_vec_ack = 2'b10;
    wr(ADDR, 8'h80, 8'h00);
    tmr_ovf = 2'b00; tmr_vec_ack = 2'b00;
    chk("R5 set wins collision", {6'b0, tmr_irq}, 8'h03);
    // R6 clears
    tmr_vec_ack = 2'b01; step(); tmr_vec_ack = 2'b00;
    chk("R6 ack clears timer0", {6'b0, tmr_irq}, 8'h02);
    wr(ADDR, 8'h80, 8'h00);
    chk("R6 write clears timer1", {6'b0, tmr_irq}, 8'h00);
    // R7 and R8 edge mode on ext 0
    wr(ADDR, 8'h01, 8'h01);
    chk("R7 mode bit", reg_rdata & 8'h05, 8'h01);
    ext_pin[0] = 1'b1;
    step(); step();
    chk("R8 not yet after 2 cycles", {7'b0, ext_irq[0]}, 8'h00);
    step();
    chk("R8 set after 3 cycles", {7'b0, ext_irq[0]}, 8'h01);
    ext_vec_ack[0] = 1'b1; step(); ext_vec_ack[0] = 1'b0;
    step(); step();
    chk("R8 held level no re-set", {7'b0, ext_irq[0]}, 8'h00);
    // R9 level mode on ext 1
    ext_pin[1] = 1'b1;
    step(); step(); step();
    chk("R9 level follows pin", {7'b0, ext_irq[1]}, 8'h01);
    ext_vec_ack[1] = 1'b1; step(); ext_vec_ack[1] = 1'b0;
    chk("R9 ack ignored", {7'b0, ext_irq[1]}, 8'h01);
    wr(ADDR, 8'h08, 8'h00);
    chk("R9 write ignored", {7'b0, ext_irq[1]}, 8'h01);
    ext_pin[1] = 1'b0;
    step(); step(); step();
    chk("R9 level drops", {7'b0, ext_irq[1]}, 8'h00);
    // R10 active-low polarity
    ext_pol[1] = 1'b0; step();
    chk("R10 low pin active", {7'b0, ext_irq[1]}, 8'h01);
    ext_pin[1] = 1'b1;
    step(); step(); step();
    chk("R10 high pin inactive", {7'b0, ext_irq[1]}, 8'h00);
    // R11 pin held active through reset, edge mode right after reset
    rst_n = 1'b0; ext_pol[0] = 1'b1; ext_pin[0] = 1'b1;
    step(); step();
    rst_n = 1'b1;
    wr(ADDR, 8'h01, 8'h01);
    repeat (5) step();
    chk("R11 no edge during warm-up", {7'b0, ext_irq[0]}, 8'h00);
    // seeded random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      reg_wr      = ($urandom % 2) == 0;
      reg_addr    = ($urandom % 10 == 0) ? 8'($urandom) : ADDR;
      reg_wmask   = 8'($urandom);
      reg_wdata   = 8'($urandom);
      tmr_ovf     = {($urandom % 6 == 0), ($urandom % 6 == 0)};
      tmr_vec_ack = {($urandom % 5 == 0), ($urandom % 5 == 0)};
      ext_vec_ack = {($urandom % 5 == 0), ($urandom % 5 == 0)};
      for (int c = 0; c < 2; c++)
        if ($urandom % 8 == 0) ext_pin[c] = ~ext_pin[c];
      if ($urandom % 64 == 0) ext_pol = 2'($urandom);
      step();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule